// File: doc/BRIEF.md
# Texture Address Swizzle Unit

This block turns a linear byte offset into a texture surface into a swizzled offset. It rotates one contiguous bit field of the offset. The lower edge of that field is fixed at bit 4. The upper edge is set at run time from a log2 texture-width code: the top bit of the field is the code plus 3. All bits below the field, and all bits above it, leave the block as they came in. The rotation is to the right within the field, by a synthesis-time step that defaults to one position. The step is taken modulo the width of the field that is active.

Offsets enter and leave on a valid/ready stream. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. With the output register enabled, which is the default, results appear one cycle after acceptance. While the consumer stalls, a held result does not change. `in_ready` then drops, so the upstream must hold its beat. With the register disabled, the block is purely combinational and the handshake passes straight through.

A width code that would put the top bit outside 5..11 is not rejected. The offset passes through unmodified, and the error flag is raised alongside that beat.

Top module: `tex_swizzle_unit`

## Requirements
- R1: For a width code c in 2..8, let N = c + 3 and W = N - 3. Output bit 4+i equals input bit 4 + ((i + ROT_STEP) mod W) for every i from 0 to W-1, which is a right rotation of field [N:4].
- R2: Output bits 3:0 and every output bit above N equal the corresponding input bits.
- R3: For a width code outside 2..8, `out_range_err` is 1 and `out_offset` equals `in_offset` bit for bit.
- R4: For a width code in 2..8, `out_range_err` is 0.
- R5: With OUT_REG=1, a beat accepted on edge k appears on the outputs with `out_valid` high right after edge k. `out_valid` falls after an edge where a result is consumed and no new beat is accepted.
- R6: With OUT_REG=1, while `out_valid` is high and `out_ready` is low, `out_valid`, `out_offset` and `out_range_err` hold their values across the edge.
- R7: With OUT_REG=1, `in_ready` equals `out_ready` OR NOT `out_valid`. With OUT_REG=0, `in_ready` equals `out_ready`, `out_valid` equals `in_valid`, and the result is valid in the same cycle.
- R8: After reset with OUT_REG=1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat this cycle |
| in_offset | input | 32 | Linear byte offset |
| in_log2w | input | 4 | Log2 of texture width; field top bit = value + 3 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer accepts the result this cycle |
| out_offset | output | 32 | Swizzled offset |
| out_range_err | output | 1 | Width code was out of range; offset passed unchanged |

## Verification
A fault in the width decoder picks the wrong candidate field. That shows at the ports in the same beat. It appears either as rotated bits above the intended top, or as untouched field bits, and the walking-one patterns make it visible on a single bit. A fault in the output register or in its load enable appears within one beat. A stalled result changes, a beat is dropped, or `in_ready` rises while a result is held, so the stall sequence is checked cycle by cycle. Sweeping every width code against every single-bit offset ties each output bit to exactly one input bit.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int unsigned SWZ_DATA_W = 32;

  typedef struct packed {
    logic                  err;
    logic [SWZ_DATA_W-1:0] data;
  } swz_beat_t;
endpackage

// File: rtl/swz_field_decode.sv
module swz_field_decode #(
  parameter int CODE_W    = 4,
  parameter int FIELD_LSB = 4,
  parameter int MIN_TOP   = 5,
  parameter int MAX_TOP   = 11
) (
  input  logic [CODE_W-1:0]        code,
  output logic [MAX_TOP:MIN_TOP]   sel,
  output logic                     code_ok
);
  localparam int TOP_OFS = FIELD_LSB - 1;
  localparam int TOP_W   = CODE_W + 1;

  logic [TOP_W-1:0] top_bit;
  assign top_bit = {1'b0, code} + TOP_W'(TOP_OFS);

  for (genvar g = MIN_TOP; g <= MAX_TOP; g++) begin : g_sel
    assign sel[g] = (top_bit == TOP_W'(g));
  end

  assign code_ok = |sel;

  always_comb begin
    a_r1_single_field: assert ($onehot0(sel)) else $error("R1: more than one field selected");
  end
endmodule

// File: rtl/swz_rotator.sv
module swz_rotator #(
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 4,
  parameter int MIN_TOP   = 5,
  parameter int MAX_TOP   = 11,
  parameter int ROT_STEP  = 1
) (
  input  logic [DATA_W-1:0]      din,
  input  logic [MAX_TOP:MIN_TOP] sel,
  input  logic                   code_ok,
  output logic [DATA_W-1:0]      dout
);
  logic [DATA_W-1:0] cand [MIN_TOP:MAX_TOP];

  for (genvar g = MIN_TOP; g <= MAX_TOP; g++) begin : g_cand
    localparam int W = g - FIELD_LSB + 1;
    localparam int R = ROT_STEP % W;
    logic [DATA_W-1:0] rot_g;
    always_comb begin
      rot_g = din;
      for (int i = 0; i < W; i++) begin
        rot_g[FIELD_LSB + i] = din[FIELD_LSB + ((i + R) % W)];
      end
    end
    assign cand[g] = rot_g;
  end

  always_comb begin
    dout = din;
    for (int g = MIN_TOP; g <= MAX_TOP; g++) begin
      if (sel[g]) dout = cand[g];
    end
  end

  always_comb begin
    a_r2_low_bits_kept: assert (dout[FIELD_LSB-1:0] == din[FIELD_LSB-1:0])
      else $error("R2: bits below field changed");
    a_r3_passthrough: assert (code_ok || dout == din)
      else $error("R3: out-of-range code altered offset");
    a_r2_high_bits_kept: assert (dout[DATA_W-1:MAX_TOP+1] == din[DATA_W-1:MAX_TOP+1])
      else $error("R2: bits above widest field changed");
  end
endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage
  import swz_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  output logic      in_ready,
  input  swz_beat_t in_beat,
  output logic      out_valid,
  input  logic      out_ready,
  output swz_beat_t out_beat
);
  if (OUT_REG) begin : g_reg
    logic      vld_q;
    swz_beat_t beat_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        beat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) beat_q <= in_beat;
      end
    end

    assign out_valid = vld_q;
    assign out_beat  = beat_q;

    a_r5_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid)
      else $error("R5: accepted beat not presented");
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_beat)))
      else $error("R6: stalled result changed");
    a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready)
      else $error("R7: input accepted while stalled");
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_beat  = in_beat;
  end
endmodule

// File: rtl/tex_swizzle_unit.sv
module tex_swizzle_unit
  import swz_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int FIELD_LSB = 4,
  parameter int MIN_TOP   = 5,
  parameter int MAX_TOP   = 11,
  parameter int ROT_STEP  = 1,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SWZ_DATA_W-1:0] in_offset,
  input  logic [CODE_W-1:0]     in_log2w,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SWZ_DATA_W-1:0] out_offset,
  output logic                  out_range_err
);
  logic [MAX_TOP:MIN_TOP] field_sel;
  logic                   code_ok;
  swz_beat_t              mid_beat, fin_beat;

  swz_field_decode #(
    .CODE_W(CODE_W), .FIELD_LSB(FIELD_LSB), .MIN_TOP(MIN_TOP), .MAX_TOP(MAX_TOP)
  ) u_decode (
    .code(in_log2w), .sel(field_sel), .code_ok(code_ok)
  );

  swz_rotator #(
    .DATA_W(SWZ_DATA_W), .FIELD_LSB(FIELD_LSB), .MIN_TOP(MIN_TOP),
    .MAX_TOP(MAX_TOP), .ROT_STEP(ROT_STEP)
  ) u_rot (
    .din(in_offset), .sel(field_sel), .code_ok(code_ok), .dout(mid_beat.data)
  );

  assign mid_beat.err = !code_ok;

  swz_out_stage #(.OUT_REG(OUT_REG)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_beat(mid_beat),
    .out_valid(out_valid), .out_ready(out_ready), .out_beat(fin_beat)
  );

  assign out_offset    = fin_beat.data;
  assign out_range_err = fin_beat.err;
endmodule

// File: tb/tex_swizzle_unit_bench.sv
module tex_swizzle_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic [31:0] in_offset = '0;
  logic [3:0]  in_log2w = '0;
  logic        r_in_ready, r_out_valid, r_err;
  logic [31:0] r_out;
  logic        c_in_ready, c_out_valid, c_err;
  logic [31:0] c_out;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  tex_swizzle_unit u_tex_swizzle_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r_in_ready),
    .in_offset(in_offset), .in_log2w(in_log2w), .out_valid(r_out_valid),
    .out_ready(out_ready), .out_offset(r_out), .out_range_err(r_err)
  );

  tex_swizzle_unit #(.OUT_REG(1'b0)) u_tex_swizzle_unit_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_offset(in_offset), .in_log2w(in_log2w), .out_valid(c_out_valid),
    .out_ready(out_ready), .out_offset(c_out), .out_range_err(c_err)
  );

  function automatic logic [32:0] model(input logic [31:0] off, input int code);
    int          top, w, r;
    logic [31:0] mask, fld, rot;
    if (code < 2 || code > 8) return {1'b1, off};
    top  = code + 3;
    w    = top - 3;
    r    = 1 % w;
    mask = (32'd1 << w) - 32'd1;
    fld  = (off >> 4) & mask;
    rot  = ((fld >> r) | (fld << (w - r))) & mask;
    return {1'b0, (off & ~(mask << 4)) | (rot << 4)};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] off, input int code);
    logic [32:0] e;
    string       tag;
    @(negedge clk);
    in_offset = off;
    in_log2w  = 4'(code);
    in_valid  = 1'b1;
    e = model(off, code);
    tag = (code < 2 || code > 8) ? "R3" : (e[32] ? "R4" : "R1/R2");
    #2;
    check(tag, {c_err, c_out}, e);
    if (code >= 2 && code <= 8) check("R4", {32'd0, c_err}, 33'd0);
    check("R7", {31'd0, c_out_valid, c_in_ready}, {31'd0, 1'b1, out_ready});
    @(posedge clk);
    #2;
    check(tag, {r_err, r_out}, e);
    check("R5", {32'd0, r_out_valid}, 33'd1);
  endtask

  initial begin
    logic [32:0] held;
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    #2;
    check("R8", {31'd0, r_out_valid, r_in_ready}, {31'd0, 2'b01});
    rst_n = 1'b1;
    for (int code = 0; code < 16; code++) begin
      for (int b = 0; b < 32; b++) apply(32'd1 << b, code);
      apply(32'hFFFF_FFFF, code);
      apply(32'h0, code);
      lcg = 32'h1234_5678 + 32'(code);
      for (int k = 0; k < 12; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        apply(lcg, code);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #2;
    check("R5", {32'd0, r_out_valid}, 33'd0);
    // R6 stall sequence
    @(negedge clk);
    out_ready = 1'b0;
    in_offset = 32'h0000_0A50;
    in_log2w  = 4'd5;
    in_valid  = 1'b1;
    held = model(32'h0000_0A50, 5);
    @(posedge clk);
    @(negedge clk);
    in_offset = 32'hDEAD_BEEF;
    in_log2w  = 4'd8;
    #1;
    check("R7", {32'd0, r_in_ready}, 33'd0);
    for (int s = 0; s < 4; s++) begin
      @(posedge clk);
      #2;
      check("R6", {r_err, r_out}, held);
      check("R6", {32'd0, r_out_valid}, 33'd1);
    end
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R7", {32'd0, r_in_ready}, 33'd1);
    @(posedge clk);
    #2;
    check("R6", {r_err, r_out}, model(32'hDEAD_BEEF, 8));
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #2;
    check("R5", {32'd0, r_out_valid}, 33'd0);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule